// File: doc/BRIEF.md
# External Pin Interrupt and Event Router

This block watches the input pins of several general-purpose ports and turns chosen pin edges into two interrupt request lines and a set of event outputs. It has sixteen channels, one per pin number. Channel n can only watch pin n, and a 4-bit port selector picks which port supplies that pin. All pins pass through a two-stage synchronizer on the core clock, and the synchronized values can be read back one port at a time. Each channel then runs through an interrupt path on the core clock with its own rising-edge and falling-edge enables. A detected edge sets a sticky flag.

Software reaches the block through a single-cycle write port and a combinational read port. Flags can be set by writing ones to a set register and cleared by writing ones to a clear register. An enable mask gates the flags. The enabled even-numbered flags are ORed onto one request line and the enabled odd-numbered flags onto the other. The same port selection drives sixteen event outputs. These are resynchronized on a separate peripheral clock.

Two sense bits switch off the interrupt path and the event path independently. Each path is run by a small state machine:
- The interrupt path has the states IP_OFF, IP_PRIME and IP_RUN. The transitions are IP_OFF→IP_PRIME when the sense bit is set, IP_PRIME→IP_RUN, and any state→IP_OFF when the sense bit is clear.
- The event path has the states EP_OFF, EP_FILL0, EP_FILL1 and EP_RUN. The transitions are EP_OFF→EP_FILL0 when the synchronized sense bit is set, EP_FILL0→EP_FILL1, EP_FILL1→EP_RUN, and any state→EP_OFF when the synchronized sense bit is clear.

The port selectors and the event sense bit are treated as quasi-static configuration when they cross into the peripheral clock.

Top module: `xint_router`

## Requirements
- R1: The read address 9+p returns the synchronized pins of port p in bits [15:0]. A pin change that is set up before core edge k is visible after edge k+1 and not after edge k.
- R2: Channel n watches pin n of the port whose number is in its 4-bit selector. Channels 0 to 7 use address 0 and channels 8 to 15 use address 1, with channel c in bits [4(c mod 8)+3 : 4(c mod 8)]. A selector value of 6 or more gives a constant-low input to both the channel and its event output.
- R3: With the rise enable set (address 2, bit n), a rising pin set up before core edge k sets flag n at edge k+3 and not earlier. Flags are read at address 4 and stay set until they are cleared.
- R4: With the fall enable set (address 3, bit n), a falling edge sets flag n with the same timing as R3. An edge whose enable is clear sets nothing, and a channel with both enables set flags on both edges.
- R5: Writing ones to address 5 sets the matching flags, and writing ones to address 6 clears them. Zero bits leave flags unchanged. Both addresses read back as zero.
- R6: When a detected edge and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: irq_even_o is the OR of flag n AND mask bit n over the even n. irq_odd_o is the same OR over the odd n. The mask is at address 7.
- R8: Address 8 bit 0 is the interrupt sense bit. While it is clear, no pin activity sets a flag. When it is set again, the first sample is taken as the reference, so a pin that changed while the path was off reports no edge.
- R9: Address 8 bit 1 is the event sense bit. While it is clear, evt_o stays all zero. Once it is written to 1 at core edge w (with the two clocks tied), evt_o is still zero after edge w+4 and carries pin data after edge w+5.
- R10: While the event path runs, evt_o[n] follows the selected pin n two peripheral edges after it is sampled. A change set up before edge k appears after edge k+1.
- R11: After reset the following hold:
  - all selectors, enables, flags and the mask are zero;
  - address 8 reads 3, so both paths are switched on;
  - both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core_i | input | 1 | Core clock for the synchronizers, interrupt path and registers |
| clk_per_i | input | 1 | Peripheral clock for the event path |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPORTS*NCH (96) | Raw pin inputs, port p pin n at bit p*16+n |
| bus_wr_i | input | 1 | Write strobe, one write per asserted core cycle |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_even_o | output | 1 | Request from enabled even-numbered flags |
| irq_odd_o | output | 1 | Request from enabled odd-numbered flags |
| evt_o | output | NCH (16) | Per-pin-number event outputs |

## Verification
The bench checks the exact edge on which a flag appears; a design with one synchronizer stage too many or too few would set the flag a cycle late or early. It aims a clear write at the very cycle a hardware edge lands; a design that let the clear win would drop that edge. It changes pins while the interrupt path is off and then switches the path back on; a design that did not reload its reference sample would raise a false flag. It also uses an out-of-range port selector and counts the fill cycles of the event path; a design that decoded the selector modulo the port count, or released the outputs early, would show stray events.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
package xint_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned ADR_W = 4;

    localparam logic [ADR_W-1:0] A_SEL_LO = 4'd0;
    localparam logic [ADR_W-1:0] A_SEL_HI = 4'd1;
    localparam logic [ADR_W-1:0] A_RISE   = 4'd2;
    localparam logic [ADR_W-1:0] A_FALL   = 4'd3;
    localparam logic [ADR_W-1:0] A_FLAG   = 4'd4;
    localparam logic [ADR_W-1:0] A_FSET   = 4'd5;
    localparam logic [ADR_W-1:0] A_FCLR   = 4'd6;
    localparam logic [ADR_W-1:0] A_MASK   = 4'd7;
    localparam logic [ADR_W-1:0] A_SENSE  = 4'd8;
    localparam logic [ADR_W-1:0] A_DIN0   = 4'd9;

    typedef enum logic [1:0] {
        IP_OFF   = 2'd0,
        IP_PRIME = 2'd1,
        IP_RUN   = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        EP_OFF   = 2'd0,
        EP_FILL0 = 2'd1,
        EP_FILL1 = 2'd2,
        EP_RUN   = 2'd3
    } evt_state_e;
endpackage

// File: rtl/xint_pin_pick.sv
`timescale 1ns/1ps
module xint_pin_pick #(
    parameter int unsigned NPORTS = 6,
    parameter int unsigned NCH    = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [NPORTS*NCH-1:0] src_i,
    input  logic [NCH*SEL_W-1:0]  sel_i,
    output logic [NCH-1:0]        pick_o
);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic [SEL_W-1:0] port_sel;
        logic             bit_v;

        assign port_sel = sel_i[n*SEL_W +: SEL_W];

        // out-of-range selector leaves the channel tied low (R2)
        always_comb begin
            bit_v = 1'b0;
            for (int p = 0; p < NPORTS; p++) begin
                if (port_sel == SEL_W'(p)) begin
                    bit_v = src_i[p*NCH + n];
                end
            end
        end

        assign pick_o[n] = bit_v;
    end
endmodule

// File: rtl/xint_irq_path.sv
`timescale 1ns/1ps
module xint_irq_path
    import xint_pkg::*;
#(
    parameter int unsigned NPORTS = 6,
    parameter int unsigned NCH    = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NPORTS*NCH-1:0] pins_i,
    input  logic [NCH*SEL_W-1:0]  sel_i,
    input  logic [NCH-1:0]        rise_en_i,
    input  logic [NCH-1:0]        fall_en_i,
    input  logic                  sense_i,
    output logic [NPORTS*NCH-1:0] din_o,
    output logic [NCH-1:0]        hw_set_o
);
    localparam int unsigned NPIN = NPORTS * NCH;

    logic [NPIN-1:0] meta_q, din_q;
    logic [NCH-1:0]  watched, cur_q, prev_q;
    irq_state_e      state_q, state_d;

    // two-stage input synchronizer, readable as data-in (R1)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            din_q  <= '0;
        end else begin
            meta_q <= pins_i;
            din_q  <= meta_q;
        end
    end

    assign din_o = din_q;

    xint_pin_pick #(
        .NPORTS (NPORTS),
        .NCH    (NCH),
        .SEL_W  (SEL_W)
    ) u_pick (
        .src_i  (din_q),
        .sel_i  (sel_i),
        .pick_o (watched)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= IP_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = IP_OFF;
        unique case (state_q)
            IP_OFF:   state_d = sense_i ? IP_PRIME : IP_OFF;
            IP_PRIME: state_d = sense_i ? IP_RUN   : IP_OFF;
            IP_RUN:   state_d = sense_i ? IP_RUN   : IP_OFF;
            default:  state_d = IP_OFF;
        endcase
    end

    // sampling stage: held while off, reloaded on both sides when priming (R8)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            unique case (state_q)
                IP_PRIME: begin
                    cur_q  <= watched;
                    prev_q <= watched;
                end
                IP_RUN: begin
                    cur_q  <= watched;
                    prev_q <= cur_q;
                end
                default: begin
                    cur_q  <= cur_q;
                    prev_q <= prev_q;
                end
            endcase
        end
    end

    // output process: enabled edges only while running (R3, R4)
    always_comb begin
        hw_set_o = '0;
        unique case (state_q)
            IP_RUN:  hw_set_o = (cur_q & ~prev_q & rise_en_i) |
                                (~cur_q & prev_q & fall_en_i);
            default: hw_set_o = '0;
        endcase
    end

    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    p_din_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q == 2'd3) |-> (din_q == $past(pins_i, 2)));

    p_no_false_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == IP_PRIME) |=> (hw_set_o == '0));

    p_idle_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sense_i) |=> (hw_set_o == '0));
endmodule

// File: rtl/xint_evt_path.sv
`timescale 1ns/1ps
module xint_evt_path
    import xint_pkg::*;
#(
    parameter int unsigned NPORTS = 6,
    parameter int unsigned NCH    = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NPORTS*NCH-1:0] pins_i,
    input  logic [NCH*SEL_W-1:0]  sel_i,
    input  logic                  sense_i,
    output logic [NCH-1:0]        evt_o
);
    logic           sense_meta_q, sense_q;
    logic [NCH-1:0] raw_pick, stage1_q, stage2_q;
    evt_state_e     state_q, state_d;

    // bring the sense bit into this clock domain
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sense_meta_q <= 1'b0;
            sense_q      <= 1'b0;
        end else begin
            sense_meta_q <= sense_i;
            sense_q      <= sense_meta_q;
        end
    end

    xint_pin_pick #(
        .NPORTS (NPORTS),
        .NCH    (NCH),
        .SEL_W  (SEL_W)
    ) u_pick (
        .src_i  (pins_i),
        .sel_i  (sel_i),
        .pick_o (raw_pick)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= EP_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = EP_OFF;
        unique case (state_q)
            EP_OFF:   state_d = sense_q ? EP_FILL0 : EP_OFF;
            EP_FILL0: state_d = sense_q ? EP_FILL1 : EP_OFF;
            EP_FILL1: state_d = sense_q ? EP_RUN   : EP_OFF;
            EP_RUN:   state_d = sense_q ? EP_RUN   : EP_OFF;
            default:  state_d = EP_OFF;
        endcase
    end

    // synchronizer flops only toggle while the path is awake
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else if (state_q != EP_OFF) begin
            stage1_q <= raw_pick;
            stage2_q <= stage1_q;
        end
    end

    // output process
    always_comb begin
        evt_o = '0;
        unique case (state_q)
            EP_RUN:  evt_o = stage2_q;
            default: evt_o = '0;
        endcase
    end

    p_evt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sense_q) |=> (evt_o == '0));

    p_evt_fill_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == EP_RUN) |->
        ($past(state_q) == EP_FILL1 || $past(state_q) == EP_RUN));

    p_evt_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == EP_RUN && $past(state_q) == EP_RUN && $past(state_q, 2) == EP_RUN)
        |-> (evt_o == $past(raw_pick, 2)));
endmodule

// File: rtl/xint_regs.sv
`timescale 1ns/1ps
module xint_regs
    import xint_pkg::*;
#(
    parameter int unsigned NPORTS = 6,
    parameter int unsigned NCH    = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic [ADR_W-1:0]      addr_i,
    input  logic [BUS_W-1:0]      wdata_i,
    output logic [BUS_W-1:0]      rdata_o,
    input  logic [NPORTS*NCH-1:0] din_i,
    input  logic [NCH-1:0]        hw_set_i,
    output logic [NCH*SEL_W-1:0]  sel_o,
    output logic [NCH-1:0]        rise_en_o,
    output logic [NCH-1:0]        fall_en_o,
    output logic [NCH-1:0]        mask_o,
    output logic                  irq_sense_o,
    output logic                  evt_sense_o,
    output logic [NCH-1:0]        flags_o
);
    localparam int unsigned SEL_BITS = NCH * SEL_W;

    logic [BUS_W-1:0] sel_lo_q, sel_hi_q;
    logic [NCH-1:0]   rise_q, fall_q, mask_q, flags_q;
    logic [1:0]       sense_q;
    logic [NCH-1:0]   sw_set, sw_clr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            mask_q   <= '0;
            sense_q  <= 2'b11;
        end else if (wr_i) begin
            case (addr_i)
                A_SEL_LO: sel_lo_q <= wdata_i;
                A_SEL_HI: sel_hi_q <= wdata_i;
                A_RISE:   rise_q   <= wdata_i[NCH-1:0];
                A_FALL:   fall_q   <= wdata_i[NCH-1:0];
                A_MASK:   mask_q   <= wdata_i[NCH-1:0];
                A_SENSE:  sense_q  <= wdata_i[1:0];
                default:  ;
            endcase
        end
    end

    assign sw_set = (wr_i && addr_i == A_FSET) ? wdata_i[NCH-1:0] : '0;
    assign sw_clr = (wr_i && addr_i == A_FCLR) ? wdata_i[NCH-1:0] : '0;

    // a hardware edge is ORed in after the clear, so it wins (R6)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= ((flags_q | sw_set) & ~sw_clr) | hw_set_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_SEL_LO: rdata_o = sel_lo_q;
            A_SEL_HI: rdata_o = sel_hi_q;
            A_RISE:   rdata_o = BUS_W'(rise_q);
            A_FALL:   rdata_o = BUS_W'(fall_q);
            A_FLAG:   rdata_o = BUS_W'(flags_q);
            A_MASK:   rdata_o = BUS_W'(mask_q);
            A_SENSE:  rdata_o = BUS_W'(sense_q);
            default: begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (addr_i == ADR_W'(A_DIN0 + p)) begin
                        rdata_o = BUS_W'(din_i[p*NCH +: NCH]);
                    end
                end
            end
        endcase
    end

    assign sel_o       = SEL_BITS'({sel_hi_q, sel_lo_q});
    assign rise_en_o   = rise_q;
    assign fall_en_o   = fall_q;
    assign mask_o      = mask_q;
    assign irq_sense_o = sense_q[0];
    assign evt_sense_o = sense_q[1];
    assign flags_o     = flags_q;

    p_hw_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_set_i != '0) |=> ((flags_q & $past(hw_set_i)) == $past(hw_set_i)));

    p_set_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == A_FSET) |=>
        ((flags_q & $past(wdata_i[NCH-1:0])) == $past(wdata_i[NCH-1:0])));

    p_clear_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == A_FCLR) |=>
        ((flags_q & $past(wdata_i[NCH-1:0]) & ~$past(hw_set_i)) == '0));

    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(wr_i && addr_i == A_FCLR)) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/xint_router.sv
`timescale 1ns/1ps
module xint_router
    import xint_pkg::*;
#(
    parameter int unsigned NPORTS = 6,
    parameter int unsigned NCH    = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                  clk_core_i,
    input  logic                  clk_per_i,
    input  logic                  rst_ni,
    input  logic [NPORTS*NCH-1:0] pins_i,
    input  logic                  bus_wr_i,
    input  logic [ADR_W-1:0]      bus_addr_i,
    input  logic [BUS_W-1:0]      bus_wdata_i,
    output logic [BUS_W-1:0]      bus_rdata_o,
    output logic                  irq_even_o,
    output logic                  irq_odd_o,
    output logic [NCH-1:0]        evt_o
);
    logic [NPORTS*NCH-1:0] din;
    logic [NCH*SEL_W-1:0]  sel;
    logic [NCH-1:0]        rise_en, fall_en, mask, flags, hw_set, active;
    logic                  irq_sense, evt_sense;

    xint_regs #(
        .NPORTS (NPORTS),
        .NCH    (NCH),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk_i       (clk_core_i),
        .rst_ni      (rst_ni),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .rdata_o     (bus_rdata_o),
        .din_i       (din),
        .hw_set_i    (hw_set),
        .sel_o       (sel),
        .rise_en_o   (rise_en),
        .fall_en_o   (fall_en),
        .mask_o      (mask),
        .irq_sense_o (irq_sense),
        .evt_sense_o (evt_sense),
        .flags_o     (flags)
    );

    xint_irq_path #(
        .NPORTS (NPORTS),
        .NCH    (NCH),
        .SEL_W  (SEL_W)
    ) u_irq (
        .clk_i     (clk_core_i),
        .rst_ni    (rst_ni),
        .pins_i    (pins_i),
        .sel_i     (sel),
        .rise_en_i (rise_en),
        .fall_en_i (fall_en),
        .sense_i   (irq_sense),
        .din_o     (din),
        .hw_set_o  (hw_set)
    );

    xint_evt_path #(
        .NPORTS (NPORTS),
        .NCH    (NCH),
        .SEL_W  (SEL_W)
    ) u_evt (
        .clk_i   (clk_per_i),
        .rst_ni  (rst_ni),
        .pins_i  (pins_i),
        .sel_i   (sel),
        .sense_i (evt_sense),
        .evt_o   (evt_o)
    );

    assign active = flags & mask;

    // even/odd request combining (R7)
    always_comb begin
        irq_even_o = 1'b0;
        irq_odd_o  = 1'b0;
        for (int n = 0; n < NCH; n++) begin
            if ((n % 2) == 0) begin
                irq_even_o = irq_even_o | active[n];
            end else begin
                irq_odd_o = irq_odd_o | active[n];
            end
        end
    end
endmodule

// File: tb/test_xint_router.sv
`timescale 1ns/1ps
module test_xint_router;
    localparam int NP = 6;
    localparam int NC = 16;
    localparam logic [3:0] AF = 4'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] pins = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = AF;
    logic [31:0] wdata = '0;
    logic [31:0] rd;
    logic        irq_even, irq_odd;
    logic [15:0] evt;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xint_router i_xint_router (
        .clk_core_i  (clk),
        .clk_per_i   (clk),
        .rst_ni      (rst_n),
        .pins_i      (pins),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rd),
        .irq_even_o  (irq_even),
        .irq_odd_o   (irq_odd),
        .evt_o       (evt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [95:0] m_s1, m_s2;
    logic [63:0] m_sel;
    logic [15:0] m_rise, m_fall, m_mask, m_flags, m_cur, m_prev, m_e1, m_e2;
    logic [1:0]  m_sense;
    logic        m_es1, m_es2;
    int          m_ist, m_est;

    function automatic logic pick(input logic [95:0] v, input logic [63:0] s, input int n);
        int port;
        port = int'(s[n*4 +: 4]);
        return (port < NP) ? v[port*NC + n] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_sel = '0; m_rise = '0; m_fall = '0;
            m_mask = '0; m_flags = '0; m_cur = '0; m_prev = '0;
            m_e1 = '0; m_e2 = '0; m_sense = 2'b11; m_es1 = 0; m_es2 = 0;
            m_ist = 0; m_est = 0;
        end else begin
            logic [15:0] w, raw, hw, nf;
            for (int n = 0; n < NC; n++) begin
                w[n]   = pick(m_s2, m_sel, n);
                raw[n] = pick(pins, m_sel, n);
            end
            hw = (m_ist == 2) ? ((m_cur & ~m_prev & m_rise) | (~m_cur & m_prev & m_fall)) : '0;
            nf = m_flags;
            if (wr && addr == 4'd5) nf = nf | wdata[15:0];
            if (wr && addr == 4'd6) nf = nf & ~wdata[15:0];
            m_flags = nf | hw;
            if (m_ist == 1) begin m_cur = w; m_prev = w; end
            else if (m_ist == 2) begin m_prev = m_cur; m_cur = w; end
            m_ist = !m_sense[0] ? 0 : ((m_ist == 0) ? 1 : 2);
            if (m_est != 0) begin m_e2 = m_e1; m_e1 = raw; end
            m_est = !m_es2 ? 0 : ((m_est == 3) ? 3 : m_est + 1);
            m_es2 = m_es1; m_es1 = m_sense[1];
            m_s2 = m_s1; m_s1 = pins;
            if (wr) begin
                case (addr)
                    4'd0: m_sel[31:0]  = wdata;
                    4'd1: m_sel[63:32] = wdata;
                    4'd2: m_rise = wdata[15:0];
                    4'd3: m_fall = wdata[15:0];
                    4'd7: m_mask = wdata[15:0];
                    4'd8: m_sense = wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    // compare against the reference every clock
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("R7 irq_even", 32'(irq_even), 32'(|(m_flags & m_mask & 16'h5555)));
            check("R7 irq_odd",  32'(irq_odd),  32'(|(m_flags & m_mask & 16'hAAAA)));
            check("R10 evt", 32'(evt), 32'((m_est == 3) ? m_e2 : 16'h0));
            if (!wr && addr == AF) check("R3 flags", rd, 32'(m_flags));
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = AF; wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd;
        addr = AF;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        cyc(4);
        rst_n = 1'b1;
        cyc(8);
        // R11 reset state
        rd_reg(4'd8, v); check("R11 sense", v, 32'h3);
        rd_reg(4'd0, v); check("R11 sel", v, 32'h0);
        rd_reg(AF, v);   check("R11 flags", v, 32'h0);
        check("R11 irq", 32'({irq_even, irq_odd}), 32'h0);

        // R1 data-in latency, port2 pin3
        @(negedge clk);
        pins[35] = 1'b1; addr = 4'd11;
        @(posedge clk); #2; check("R1 din after one edge", rd, 32'h0);
        @(posedge clk); #2; check("R1 din after two edges", rd, 32'h8);
        @(negedge clk); addr = AF;

        // configuration: ch3->port2, ch4->port1, ch5->port9 (invalid)
        wr_reg(4'd0, 32'h0091_2000);
        wr_reg(4'd2, 32'h0068);
        wr_reg(4'd3, 32'h0050);
        wr_reg(4'd7, 32'hFFFF);
        cyc(8);
        wr_reg(4'd6, 32'hFFFF);

        // R3 rise timing
        @(negedge clk); pins[35] = 1'b0;
        cyc(6);
        rd_reg(AF, v); check("R4 no flag on disabled fall", v, 32'h0);
        @(negedge clk); pins[35] = 1'b1;
        repeat (3) @(posedge clk);
        #2; check("R3 flag not before edge k+3", rd & 32'h8, 32'h0);
        @(posedge clk); #2;
        check("R3 flag at edge k+3", rd & 32'h8, 32'h8);
        check("R7 odd line from flag3", 32'(irq_odd), 32'h1);
        wr_reg(4'd6, 32'hFFFF);

        // R2 other ports on pin 3 ignored, invalid selector on ch5
        @(negedge clk); pins[3] = 1'b1; pins[19] = 1'b1;
        pins[5] = 1; pins[21] = 1; pins[37] = 1; pins[53] = 1; pins[69] = 1; pins[85] = 1;
        cyc(6);
        rd_reg(AF, v); check("R2 unselected ports and invalid selector", v, 32'h0);
        check("R2 evt5 low with invalid selector", 32'(evt[5]), 32'h0);
        check("R10 evt3 follows port2 pin3", 32'(evt[3]), 32'h1);
        @(negedge clk); pins[3] = 1'b0; pins[19] = 1'b0;

        // R4 fall on ch4, both edges on ch6
        @(negedge clk); pins[20] = 1'b1;
        cyc(6);
        rd_reg(AF, v); check("R4 rise ignored on fall-only ch4", v & 32'h10, 32'h0);
        @(negedge clk); pins[20] = 1'b0;
        cyc(6);
        rd_reg(AF, v); check("R4 fall sets ch4", v & 32'h10, 32'h10);
        wr_reg(4'd6, 32'hFFFF);
        @(negedge clk); pins[6] = 1'b1;
        cyc(6);
        rd_reg(AF, v); check("R4 both-edge ch6 rise", v, 32'h40);
        wr_reg(4'd6, 32'hFFFF);
        @(negedge clk); pins[6] = 1'b0;
        cyc(6);
        rd_reg(AF, v); check("R4 both-edge ch6 fall", v, 32'h40);

        // R5 software set / clear, R7 masking
        wr_reg(4'd6, 32'hFFFF);
        wr_reg(4'd5, 32'h8001);
        rd_reg(AF, v); check("R5 set ones", v, 32'h8001);
        wr_reg(4'd6, 32'h0001);
        rd_reg(AF, v); check("R5 clear only ones", v, 32'h8000);
        rd_reg(4'd5, v); check("R5 set reg reads zero", v, 32'h0);
        rd_reg(4'd6, v); check("R5 clear reg reads zero", v, 32'h0);
        check("R7 odd from flag15", 32'({irq_even, irq_odd}), 32'h1);
        wr_reg(4'd7, 32'h7FFF);
        check("R7 masked flag15", 32'(irq_odd), 32'h0);
        wr_reg(4'd5, 32'h0004);
        check("R7 even from flag2", 32'(irq_even), 32'h1);
        wr_reg(4'd7, 32'hFFFF);

        // R6 hardware set wins over same-cycle clear
        @(negedge clk); pins[35] = 1'b0;
        cyc(6);
        wr_reg(4'd6, 32'hFFFF);
        @(negedge clk); pins[35] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); wr = 1'b1; addr = 4'd6; wdata = 32'h8;
        @(negedge clk); wr = 1'b0; addr = AF; wdata = '0;
        rd_reg(AF, v); check("R6 hardware edge beats clear", v & 32'h8, 32'h8);

        // R8 interrupt sense off, then re-enable with changed pins
        wr_reg(4'd8, 32'h2);
        wr_reg(4'd6, 32'hFFFF);
        @(negedge clk); pins[35] = 1'b0; pins[6] = 1'b1;
        cyc(6);
        rd_reg(AF, v); check("R8 no flags while off", v, 32'h0);
        wr_reg(4'd8, 32'h3);
        cyc(8);
        rd_reg(AF, v); check("R8 no false edge on re-enable", v, 32'h0);
        @(negedge clk); pins[35] = 1'b1;
        cyc(6);
        rd_reg(AF, v); check("R8 edges resume", v, 32'h8);

        // R9 event sense
        wr_reg(4'd8, 32'h1);
        cyc(6);
        check("R9 events idle when off", 32'(evt), 32'h0);
        wr_reg(4'd8, 32'h3);
        repeat (4) @(posedge clk);
        #2; check("R9 still filling after w+4", 32'(evt), 32'h0);
        @(posedge clk); #2;
        check("R9 live after w+5", 32'(evt & 16'h8), 32'h8);

        // R10 event latency
        @(negedge clk); pins[35] = 1'b0;
        @(posedge clk); #2; check("R10 evt3 unchanged after edge k", 32'(evt[3]), 32'h1);
        @(posedge clk); #2; check("R10 evt3 low after edge k+1", 32'(evt[3]), 32'h0);

        cyc(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule